// File: doc/BRIEF.md
# Packed Int8 Multiply-Accumulate Function Unit

This unit sits beside a RISC-V core and receives commands through a valid/ready port. Each command carries a 7-bit selector and two 32-bit source operands, and each command returns one 32-bit result in the cycle it is accepted. The unit holds two pieces of state: a signed offset register and a signed 32-bit accumulator.

Three selector values do the work. One loads the offset. One clears the accumulator. One adds a four-lane int8 dot product to the accumulator. In each lane the offset is added to the byte of the first operand, and that sum is multiplied by the matching byte of the second operand. A convolution inner loop loads the offset once, clears the accumulator, issues a run of dot-product commands, and reads the total from the response of the next command.

Top module: `mac4_unit`

## Requirements
- R1: A synchronous reset, active high, sets both the offset and the accumulator to zero, so `rsp_data` reads 0 after reset.
- R2: `cmd_ready` is always 1. `rsp_valid` is high in exactly the cycles in which `cmd_valid` is high, so every command finishes in one cycle.
- R3: `rsp_data` always shows the accumulator register. During a dot-product command it carries the value from before that command, and the updated total appears in the next cycle.
- R4: Selector 0 loads the offset with `cmd_a[8:0]`, read as a signed 9-bit value. Any higher bits of `cmd_a` are ignored.
- R5: Selector 1 sets the accumulator to zero.
- R6: Selector 2 adds the sum over i = 0..3 of (A_i + offset) * B_i to the accumulator, where A_i = `cmd_a[8i+7:8i]` and B_i = `cmd_b[8i+7:8i]` are signed int8 values, and the offset is sign-extended before the add.
- R7: The accumulator wraps modulo 2^32 when the total goes past the signed 32-bit range.
- R8: A selector value from 3 to 127, or any cycle in which `cmd_valid` is low, leaves the offset and the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The unit accepts a command (always 1) |
| cmd_sel | input | 7 | Command selector: 0 load offset, 1 clear, 2 dot-product accumulate |
| cmd_a | input | 32 | First operand: four packed int8 values, or the offset value |
| cmd_b | input | 32 | Second operand: four packed int8 values |
| rsp_valid | output | 1 | A response is presented |
| rsp_data | output | 32 | The current accumulator value |

## Verification
On every cycle the assertions check the following: an accepted command completes at once; an offset load lands in the register; a clear leaves zero; a dot-product command raises the accumulator by exactly the computed dot value in the next cycle; and idle or unknown commands leave both registers unchanged. Only the bench's scenarios can show that the dot value itself is right. To do that, the bench sweeps every first-lane byte against a spread of second-operand bytes, under extreme and ordinary offsets. The bench scenarios also show signed wrap of the accumulator, that the upper bits of an offset load are ignored, and that reset clears the offset. The offset is observed through later products.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
   localparam int SEL_W = 7;

   typedef enum logic [SEL_W-1:0] {
      OP_SET_OFS = 7'd0,
      OP_CLR_ACC = 7'd1,
      OP_MAC     = 7'd2
   } mac4_op_e;
endpackage

// File: rtl/mac4_lane.sv
module mac4_lane #(
   parameter int LANE_W = 8,
   parameter int OFS_W  = 9,
   localparam int SUM_W  = OFS_W + 1,
   localparam int PROD_W = SUM_W + LANE_W
) (
   input  logic [LANE_W-1:0]        a_byte,
   input  logic [LANE_W-1:0]        b_byte,
   input  logic signed [OFS_W-1:0]  ofs,
   output logic signed [PROD_W-1:0] prod
);
   logic signed [SUM_W-1:0]  biased;
   logic signed [PROD_W-1:0] biased_x;
   logic signed [PROD_W-1:0] b_x;

   always_comb begin
      biased   = $signed({{(SUM_W-LANE_W){a_byte[LANE_W-1]}}, a_byte}) +
                 $signed({ofs[OFS_W-1], ofs});
      biased_x = $signed({{(PROD_W-SUM_W){biased[SUM_W-1]}}, biased});
      b_x      = $signed({{(PROD_W-LANE_W){b_byte[LANE_W-1]}}, b_byte});
      prod     = biased_x * b_x;
   end
endmodule

// File: rtl/mac4_dot.sv
module mac4_dot #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int OFS_W  = 9,
   parameter int ACC_W  = 32,
   localparam int OP_W   = LANES * LANE_W,
   localparam int PROD_W = OFS_W + 1 + LANE_W,
   localparam int DOT_W  = PROD_W + $clog2(LANES)
) (
   input  logic [OP_W-1:0]          opa,
   input  logic [OP_W-1:0]          opb,
   input  logic signed [OFS_W-1:0]  ofs,
   output logic signed [ACC_W-1:0]  dot
);
   logic signed [PROD_W-1:0] prods [LANES];
   logic signed [DOT_W-1:0]  partial [LANES+1];

   assign partial[0] = '0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      mac4_lane #(.LANE_W(LANE_W), .OFS_W(OFS_W)) u_lane (
         .a_byte(opa[i*LANE_W +: LANE_W]),
         .b_byte(opb[i*LANE_W +: LANE_W]),
         .ofs   (ofs),
         .prod  (prods[i])
      );
      assign partial[i+1] = partial[i] +
         $signed({{(DOT_W-PROD_W){prods[i][PROD_W-1]}}, prods[i]});
   end

   if (ACC_W >= DOT_W) begin : g_widen
      assign dot = $signed({{(ACC_W-DOT_W){partial[LANES][DOT_W-1]}}, partial[LANES]});
   end else begin : g_narrow
      assign dot = partial[LANES][ACC_W-1:0];
   end
endmodule

// File: rtl/mac4_regs.sv
module mac4_regs #(
   parameter int OFS_W = 9,
   parameter int ACC_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     do_set,
   input  logic                     do_clr,
   input  logic                     do_mac,
   input  logic [OFS_W-1:0]         ofs_in,
   input  logic signed [ACC_W-1:0]  dot,
   output logic signed [OFS_W-1:0]  ofs_q,
   output logic signed [ACC_W-1:0]  acc_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ofs_q <= '0;
      end else if (do_set) begin
         ofs_q <= $signed(ofs_in);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || do_clr) begin
         acc_q <= '0;
      end else if (do_mac) begin
         acc_q <= acc_q + dot;
      end
   end
endmodule

// File: rtl/mac4_unit.sv
module mac4_unit
   import mac4_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int OFS_W  = 9,
   parameter int ACC_W  = 32,
   localparam int OP_W  = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [SEL_W-1:0]  cmd_sel,
   input  logic [OP_W-1:0]   cmd_a,
   input  logic [OP_W-1:0]   cmd_b,
   output logic              rsp_valid,
   output logic [ACC_W-1:0]  rsp_data
);
   if (LANES < 1) begin : g_bad_lanes
      $error("mac4_unit: LANES must be at least 1");
   end
   if (OFS_W <= LANE_W) begin : g_bad_ofs
      $error("mac4_unit: OFS_W must exceed LANE_W");
   end
   if (OFS_W > OP_W) begin : g_bad_ofs_src
      $error("mac4_unit: OFS_W must fit in an operand");
   end
   if (ACC_W < 2 * LANE_W) begin : g_bad_acc
      $error("mac4_unit: ACC_W too narrow");
   end

   logic                    do_set, do_clr, do_mac;
   logic signed [OFS_W-1:0] ofs_q;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] dot_val;

   always_comb begin
      do_set = cmd_valid && (cmd_sel == OP_SET_OFS);
      do_clr = cmd_valid && (cmd_sel == OP_CLR_ACC);
      do_mac = cmd_valid && (cmd_sel == OP_MAC);
   end

   mac4_dot #(
      .LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)
   ) u_dot (
      .opa(cmd_a),
      .opb(cmd_b),
      .ofs(ofs_q),
      .dot(dot_val)
   );

   mac4_regs #(.OFS_W(OFS_W), .ACC_W(ACC_W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .do_set(do_set),
      .do_clr(do_clr),
      .do_mac(do_mac),
      .ofs_in(cmd_a[OFS_W-1:0]),
      .dot   (dot_val),
      .ofs_q (ofs_q),
      .acc_q (acc_q)
   );

   assign cmd_ready = 1'b1;
   assign rsp_valid = cmd_valid;
   assign rsp_data  = acc_q;
endmodule

// File: rtl/mac4_unit_chk.sv
module mac4_unit_chk #(
   parameter int OFS_W = 9,
   parameter int ACC_W = 32,
   parameter int OP_W  = 32,
   parameter int SEL_W = 7
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    cmd_valid,
   input logic                    cmd_ready,
   input logic [SEL_W-1:0]        cmd_sel,
   input logic [OP_W-1:0]         cmd_a,
   input logic                    rsp_valid,
   input logic [ACC_W-1:0]        rsp_data,
   input logic [OFS_W-1:0]        ofs_q,
   input logic [ACC_W-1:0]        dot_val
);
   // R2: an accepted command completes in the same cycle
   assert_done_R2: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> (cmd_ready && rsp_valid));

   // R2: no response without a command
   assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> !rsp_valid);

   // R4: offset load takes the low operand bits
   assert_set_ofs_R4: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_sel == SEL_W'(0)) |=> (ofs_q == $past(cmd_a[OFS_W-1:0])));

   // R5: clear leaves zero
   assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_sel == SEL_W'(1)) |=> (rsp_data == '0));

   // R6: accumulate adds the dot value one cycle later
   assert_mac_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_sel == SEL_W'(2)) |=>
         (rsp_data == ACC_W'($past(rsp_data) + $past(dot_val))));

   // R8: idle or unknown commands hold all state
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(cmd_valid && cmd_sel <= SEL_W'(2)) |=> ($stable(rsp_data) && $stable(ofs_q)));
endmodule

bind mac4_unit mac4_unit_chk #(
   .OFS_W(OFS_W), .ACC_W(ACC_W), .OP_W(OP_W), .SEL_W(mac4_pkg::SEL_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_sel  (cmd_sel),
   .cmd_a    (cmd_a),
   .rsp_valid(rsp_valid),
   .rsp_data (rsp_data),
   .ofs_q    (ofs_q),
   .dot_val  (dot_val)
);

// File: tb/mac4_unit_tb.sv
`timescale 1ns/1ps
module mac4_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [6:0]  cmd_sel = '0;
   logic [31:0] cmd_a = '0;
   logic [31:0] cmd_b = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;

   int          checks = 0;
   int          errors = 0;
   int          m_ofs = 0;
   logic [31:0] m_acc = '0;

   always #2.5 clk = ~clk;

   mac4_unit u_dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_sel(cmd_sel), .cmd_a(cmd_a), .cmd_b(cmd_b),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int dot4(input logic [31:0] a, input logic [31:0] b, input int ofs);
      int s = 0;
      for (int i = 0; i < 4; i++) begin
         byte ab = a[i*8 +: 8];
         byte bb = b[i*8 +: 8];
         s += (int'(ab) + ofs) * int'(bb);
      end
      return s;
   endfunction

   // Drive one cycle, check the response, then advance the model
   task automatic issue(input bit v, input logic [6:0] sel, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
      @(negedge clk);
      cmd_valid = v; cmd_sel = sel; cmd_a = a; cmd_b = b;
      #1;
      chk(rsp_valid == v && cmd_ready, {tag, " R2 handshake"},
          {30'd0, cmd_ready, rsp_valid}, {30'd0, 1'b1, v});
      chk(rsp_data == m_acc, {tag, " R3 response"}, rsp_data, m_acc);
      if (v) begin
         case (sel)
            7'd0: begin
               logic signed [8:0] t;
               t = a[8:0];
               m_ofs = int'(t);
            end
            7'd1: m_acc = '0;
            7'd2: m_acc = m_acc + 32'(dot4(a, b, m_ofs));
            default: ;
         endcase
      end
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst = 1'b1; cmd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_acc = '0; m_ofs = 0;
      #1;
      chk(rsp_data == 32'd0, "R1 reset clears accumulator", rsp_data, 32'd0);
   endtask

   task automatic finish_sim;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      int ofs_list[5] = '{0, -256, 255, -1, 100};
      bit crossed;
      do_reset();

      // R3 R6: hand-computed case, 4 * (2 * 3) = 24
      issue(1, 7'd2, 32'h02020202, 32'h03030303, "R6 small");
      issue(1, 7'd0, 32'h0, 32'h0, "R3 after mac");
      chk(rsp_data == 32'd24, "R3 R6 updated total", rsp_data, 32'd24);

      // R5: clear
      issue(1, 7'd1, 32'h0, 32'h0, "R5 clear");
      issue(0, 7'd0, 32'h0, 32'h0, "R5 after clear");
      chk(rsp_data == 32'd0, "R5 cleared", rsp_data, 32'd0);

      // R4: upper bits ignored, offset -1 gives per-lane (a-1)*b
      issue(1, 7'd0, 32'hABCDE1FF, 32'h0, "R4 load");
      issue(1, 7'd2, 32'h01010101, 32'h05050505, "R4 use");
      issue(0, 7'd0, 32'h0, 32'h0, "R4 check");
      chk(rsp_data == 32'd0, "R4 offset -1 from low bits", rsp_data, 32'd0);

      // R8: idle with clear selector, and all unknown selectors
      issue(1, 7'd0, 32'h00000003, 32'h0, "R8 set");
      issue(1, 7'd2, 32'h01010101, 32'h01010101, "R8 seed");
      issue(0, 7'd1, 32'h0, 32'h0, "R8 idle clear");
      issue(0, 7'd2, 32'h7F7F7F7F, 32'h7F7F7F7F, "R8 idle mac");
      for (int s = 3; s < 128; s++)
         issue(1, 7'(s), 32'h000001FF, 32'h12345678, "R8 unknown sel");
      issue(1, 7'd2, 32'h00000000, 32'h01010101, "R8 offset kept");
      issue(0, 7'd0, 32'h0, 32'h0, "R8 observe");
      chk(rsp_data == 32'd28, "R8 state held (16+12)", rsp_data, 32'd28);

      // R6: sweep every first-lane byte under several offsets
      foreach (ofs_list[k]) begin
         issue(1, 7'd0, 32'(ofs_list[k]), 32'h0, "R4 sweep load");
         issue(1, 7'd1, 32'h0, 32'h0, "R5 sweep clear");
         for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y += 5) begin
               logic [7:0] xb, yb;
               xb = 8'(x); yb = 8'(y);
               issue(1, 7'd2, {xb + 8'd77, ~xb, xb ^ 8'h5A, xb},
                     {xb, ~yb, yb + 8'd3, yb}, "R6 sweep");
            end
         end
      end

      // R7: drive the total past +2^31 and check wrap
      issue(1, 7'd0, 32'h00000100, 32'h0, "R7 load -256");
      issue(1, 7'd1, 32'h0, 32'h0, "R7 clear");
      crossed = 1'b0;
      for (int n = 0; n < 11000; n++) begin
         issue(1, 7'd2, 32'h80808080, 32'h80808080, "R7 wrap");
         if (m_acc[31]) crossed = 1'b1;
      end
      chk(crossed, "R7 wrapped to negative", {31'd0, crossed}, 32'd1);

      // R1: reset mid-run clears offset too
      issue(1, 7'd0, 32'h00000050, 32'h0, "R1 set");
      do_reset();
      issue(1, 7'd2, 32'h00000000, 32'h01010101, "R1 mac after reset");
      issue(0, 7'd0, 32'h0, 32'h0, "R1 observe");
      chk(rsp_data == 32'd0, "R1 offset cleared", rsp_data, 32'd0);

      finish_sim();
   end
endmodule